// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels and turns their expiry pulses into interrupt deliveries. Each channel is delivered one of two ways. It can drive one of a bank of interrupt lines, chosen by a per-channel route field or by a fixed legacy assignment. It can instead post a single 32-bit message write to a 32-bit address. Level-type channels latch a status bit and hold their line until software clears the bit by writing ones to the status clear port. Edge-type channels pulse their line for exactly one clock.

Two external legacy interrupt sources pass through the block: a periodic interval timer and a real-time clock. They reach fixed lines while legacy replacement mode is off and are blocked while it is on. An enable output tells the interval timer whether it owns its line. Lines at or above a configurable base index are active-low. The comparators, the main counter and the bus transaction itself are outside this block.

Top module: `irq_router_top`

## Requirements
- R1: After reset the status vector is 0 and `msg_valid` is 0. `pit_gate_en` is 1. Every line is at its deasserted level: low below `LOW_BASE` (default 16) and high at or above it.
- R2: With legacy mode off, an expiry on a live channel in line mode drives the line whose index equals that channel's route field (`ch_route[c*RW +: RW]`, RW = 5 by default). A route value of `NLINE` or more drives no line. The line changes after the clock edge that samples the expiry.
- R3: On an expiry, a level-type channel (`ch_level` bit 1) sets its status bit and holds its line asserted. A write with `sts_clr_we` high clears only the status bits whose `sts_clr_mask` bit is 1, and deasserts their lines; mask bits at 0 change nothing. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R4: On an expiry, an edge-type channel (`ch_level` bit 0) asserts its line for exactly one clock and leaves its status bit at 0.
- R5: Lines with index `LOW_BASE` or higher are driven low when asserted and high when deasserted.
- R6: With `legacy_mode` high, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Other channels keep using their route fields.
- R7: A channel's status bit is cleared, and its line deasserted, in the cycle after `glob_en` or that channel's `ch_en` is low. An expiry while either is low has no effect.
- R8: A live channel with `ch_msg_en` set queues one message write per expiry, using its `ch_msg_addr` and `ch_msg_data` words, and drives no line. `msg_valid` rises two edges after the expiry is sampled. `msg_valid`, `msg_addr` and `msg_data` hold steady until `msg_ready` is high.
- R9: A channel with `ch_msg_en` set has its status bit cleared and its line deasserted in the next cycle.
- R10: While `legacy_mode` is high, `pit_in` and `rtc_in` do not reach lines 0 and 8, and `pit_gate_en` is 0 from the next cycle.
- R11: When legacy mode is left, line 0 is low and stays low until `pit_in` changes. Line 8 follows the current `rtc_in` level, and `pit_gate_en` returns to 1. With legacy mode off, a change on `pit_in` and the level of `rtc_in` appear on lines 0 and 8 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glob_en | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy replacement routing on |
| ch_en | input | NCH | Per-channel interrupt enable |
| ch_level | input | NCH | 1 = level delivery, 0 = edge delivery |
| ch_msg_en | input | NCH | Deliver by message write instead of a line |
| ch_route | input | NCH*RW | Per-channel target line index |
| ch_msg_addr | input | NCH*32 | Per-channel message address |
| ch_msg_data | input | NCH*32 | Per-channel message data |
| expire | input | NCH | One-cycle expiry pulse per channel |
| sts_clr_we | input | 1 | Status clear write strobe |
| sts_clr_mask | input | NCH | Ones clear matching status bits |
| pit_in | input | 1 | External interval-timer interrupt |
| rtc_in | input | 1 | External real-time clock interrupt |
| msg_ready | input | 1 | Message sink accepts the write |
| irq_line | output | NLINE | Interrupt line bank |
| status | output | NCH | Level interrupt status |
| pit_gate_en | output | 1 | Interval timer may drive its line |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The properties are checked on every cycle. They cover the clearing of status by the enables and by message mode, write-one-to-clear behaviour, edge pulses that never leave status behind, the stable message request while it waits for ready, and the interval-timer enable in legacy mode. Other behaviours can only be shown by the bench's directed scenarios. These are the choice of line index (route field against legacy override), the active-low inversion of the upper lines, the count of message writes produced by repeated expiries, and how lines 0 and 8 are restored when legacy mode is left.

// File: rtl/tirq_pkg.sv
package tirq_pkg;

  // Line index a channel targets, with the legacy override applied.
  function automatic int unsigned pick_route(input logic legacy, input int unsigned ch,
                                             input int unsigned cfg_route,
                                             input int unsigned leg_a, input int unsigned leg_b);
    if (legacy && ch == 0) return leg_a;
    if (legacy && ch == 1) return leg_b;
    return cfg_route;
  endfunction

  // Upper lines are wired active-low.
  function automatic logic low_active(input int unsigned line, input int unsigned base);
    return line >= base;
  endfunction

endpackage

// File: rtl/tirq_chan.sv
module tirq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic lvl_mode,
  input  logic msg_en,
  input  logic expire,
  input  logic clr_hit,
  output logic sts_q,
  output logic pulse_q,
  output logic msg_fire
);
  logic hit;
  assign hit      = expire && live;
  assign msg_fire = hit && msg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit && !msg_en && !lvl_mode;
      if (!live || msg_en)  sts_q <= 1'b0;
      else if (hit)         sts_q <= lvl_mode;
      else if (clr_hit)     sts_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tirq_legacy.sv
module tirq_legacy (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy,
  input  logic pit_in,
  input  logic rtc_in,
  output logic pit_q,
  output logic rtc_q,
  output logic pit_gate
);
  logic pit_prev;
  logic pit_change;
  assign pit_change = pit_in != pit_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pit_prev <= 1'b0;
      pit_q    <= 1'b0;
      rtc_q    <= 1'b0;
      pit_gate <= 1'b1;
    end else begin
      pit_prev <= pit_in;
      rtc_q    <= rtc_in;
      pit_gate <= !legacy;
      if (legacy)          pit_q <= 1'b0;
      else if (pit_change) pit_q <= pit_in;
    end
  end
endmodule

// File: rtl/tirq_linemap.sv
module tirq_linemap #(
  parameter int NCH       = 4,
  parameter int NLINE     = 24,
  parameter int RW        = 5,
  parameter int LOW_BASE  = 16,
  parameter int LEG0_LINE = 0,
  parameter int LEG1_LINE = 8
) (
  input  logic              legacy,
  input  logic [NCH-1:0]    drive,
  input  logic [NCH*RW-1:0] route,
  input  logic              pit_q,
  input  logic              rtc_q,
  output logic [NLINE-1:0]  lines
);
  logic [RW-1:0]    eff [NCH];
  logic [NLINE-1:0] act;

  for (genvar c = 0; c < NCH; c++) begin : g_eff
    assign eff[c] = RW'(tirq_pkg::pick_route(legacy, c, int'(route[c*RW +: RW]),
                                             LEG0_LINE, LEG1_LINE));
  end

  always_comb begin
    for (int l = 0; l < NLINE; l++) begin
      act[l] = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (drive[c] && (int'(eff[c]) == l)) act[l] = 1'b1;
      end
      if (!legacy && l == LEG0_LINE && pit_q) act[l] = 1'b1;
      if (!legacy && l == LEG1_LINE && rtc_q) act[l] = 1'b1;
    end
  end

  for (genvar l = 0; l < NLINE; l++) begin : g_pol
    if (tirq_pkg::low_active(l, LOW_BASE)) begin : g_low
      assign lines[l] = ~act[l];
    end else begin : g_high
      assign lines[l] = act[l];
    end
  end
endmodule

// File: rtl/tirq_msg.sv
module tirq_msg #(
  parameter int NCH    = 4,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fire,
  input  logic [NCH*32-1:0] addr_in,
  input  logic [NCH*32-1:0] data_in,
  input  logic              ready,
  output logic              valid_q,
  output logic [31:0]       addr_q,
  output logic [31:0]       data_q
);
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend [NCH];
  logic [SW-1:0]     sel;
  logic              any;
  logic              take;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pend[c] != '0) begin
        any = 1'b1;
        sel = SW'(c);
      end
    end
  end

  assign take = any && (!valid_q || ready);

  for (genvar c = 0; c < NCH; c++) begin : g_pend
    logic dec;
    assign dec = take && (sel == SW'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) pend[c] <= '0;
      else if (fire[c] && !dec) begin
        if (pend[c] != PMAX) pend[c] <= pend[c] + 1'b1;
      end else if (!fire[c] && dec) pend[c] <= pend[c] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      addr_q  <= addr_in[sel*32 +: 32];
      data_q  <= data_in[sel*32 +: 32];
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top #(
  parameter int NCH       = 4,
  parameter int NLINE     = 24,
  parameter int LOW_BASE  = 16,
  parameter int LEG0_LINE = 0,
  parameter int LEG1_LINE = 8,
  parameter int PEND_W    = 2,
  localparam int RW       = $clog2(NLINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              legacy_mode,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    ch_level,
  input  logic [NCH-1:0]    ch_msg_en,
  input  logic [NCH*RW-1:0] ch_route,
  input  logic [NCH*32-1:0] ch_msg_addr,
  input  logic [NCH*32-1:0] ch_msg_data,
  input  logic [NCH-1:0]    expire,
  input  logic              sts_clr_we,
  input  logic [NCH-1:0]    sts_clr_mask,
  input  logic              pit_in,
  input  logic              rtc_in,
  input  logic              msg_ready,
  output logic [NLINE-1:0]  irq_line,
  output logic [NCH-1:0]    status,
  output logic              pit_gate_en,
  output logic              msg_valid,
  output logic [31:0]       msg_addr,
  output logic [31:0]       msg_data
);
  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] chan_live;
  logic [NCH-1:0] chan_pulse;
  logic [NCH-1:0] chan_drive;
  logic [NCH-1:0] msg_fire;
  logic           pit_q;
  logic           rtc_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign chan_live[c] = glob_en && ch_en[c];
    tirq_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .live     (chan_live[c]),
      .lvl_mode (ch_level[c]),
      .msg_en   (ch_msg_en[c]),
      .expire   (expire[c]),
      .clr_hit  (sts_clr_we && sts_clr_mask[c]),
      .sts_q    (status[c]),
      .pulse_q  (chan_pulse[c]),
      .msg_fire (msg_fire[c])
    );
  end

  assign chan_drive = status | chan_pulse;

  tirq_legacy u_legacy (
    .clk      (clk),
    .rst_n    (rst_n),
    .legacy   (legacy_mode),
    .pit_in   (pit_in),
    .rtc_in   (rtc_in),
    .pit_q    (pit_q),
    .rtc_q    (rtc_q),
    .pit_gate (pit_gate_en)
  );

  tirq_linemap #(
    .NCH(NCH), .NLINE(NLINE), .RW(RW), .LOW_BASE(LOW_BASE),
    .LEG0_LINE(LEG0_LINE), .LEG1_LINE(LEG1_LINE)
  ) u_map (
    .legacy (legacy_mode),
    .drive  (chan_drive),
    .route  (ch_route),
    .pit_q  (pit_q),
    .rtc_q  (rtc_q),
    .lines  (irq_line)
  );

  tirq_msg #(.NCH(NCH), .PEND_W(PEND_W)) u_msg (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (msg_fire),
    .addr_in (ch_msg_addr),
    .data_in (ch_msg_data),
    .ready   (msg_ready),
    .valid_q (msg_valid),
    .addr_q  (msg_addr),
    .data_q  (msg_data)
  );
endmodule

// File: rtl/tirq_chk.sv
module tirq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           glob_en,
  input logic           legacy_mode,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_msg_en,
  input logic [NCH-1:0] expire,
  input logic           sts_clr_we,
  input logic [NCH-1:0] sts_clr_mask,
  input logic [NCH-1:0] status,
  input logic [NCH-1:0] chan_pulse,
  input logic           pit_gate_en,
  input logic           msg_valid,
  input logic           msg_ready,
  input logic [31:0]    msg_addr,
  input logic [31:0]    msg_data
);
  assert_glob_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> status == '0);

  assert_legacy_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_mode |=> !pit_gate_en);

  assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_ch_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> !status[c]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr_we && sts_clr_mask[c] && !expire[c] |=> !status[c]);
    assert_msg_mode_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_msg_en[c] |=> !status[c]);
    assert_edge_from_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      chan_pulse[c] |-> $past(expire[c]) && !status[c]);
  end
endmodule

bind irq_router_top tirq_chk #(.NCH(NCH)) u_tirq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .glob_en      (glob_en),
  .legacy_mode  (legacy_mode),
  .ch_en        (ch_en),
  .ch_msg_en    (ch_msg_en),
  .expire       (expire),
  .sts_clr_we   (sts_clr_we),
  .sts_clr_mask (sts_clr_mask),
  .status       (status),
  .chan_pulse   (chan_pulse),
  .pit_gate_en  (pit_gate_en),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_addr     (msg_addr),
  .msg_data     (msg_data)
);

// File: tb/test_irq_router_top.sv
module test_irq_router_top;
  localparam int NCH = 4;
  localparam int NLINE = 24;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob_en = 1'b1;
  logic legacy_mode = 1'b0;
  logic [NCH-1:0] ch_en = '1;
  logic [NCH-1:0] ch_level = '0;
  logic [NCH-1:0] ch_msg_en = '0;
  logic [NCH*RW-1:0] ch_route = '1;
  logic [NCH*32-1:0] ch_msg_addr = '0;
  logic [NCH*32-1:0] ch_msg_data = '0;
  logic [NCH-1:0] expire = '0;
  logic sts_clr_we = 1'b0;
  logic [NCH-1:0] sts_clr_mask = '0;
  logic pit_in = 1'b0;
  logic rtc_in = 1'b0;
  logic msg_ready = 1'b0;
  logic [NLINE-1:0] irq_line;
  logic [NCH-1:0] status;
  logic pit_gate_en;
  logic msg_valid;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_router_top i_irq_router_top (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .legacy_mode(legacy_mode),
    .ch_en(ch_en), .ch_level(ch_level), .ch_msg_en(ch_msg_en), .ch_route(ch_route),
    .ch_msg_addr(ch_msg_addr), .ch_msg_data(ch_msg_data), .expire(expire),
    .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask), .pit_in(pit_in),
    .rtc_in(rtc_in), .msg_ready(msg_ready), .irq_line(irq_line), .status(status),
    .pit_gate_en(pit_gate_en), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_route(input int c, input int r);
    ch_route[c*RW +: RW] = RW'(r);
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    expire = m;
    step();
    expire = '0;
  endtask

  task automatic clear_all();
    sts_clr_we = 1'b1;
    sts_clr_mask = '1;
    step();
    sts_clr_we = 1'b0;
    sts_clr_mask = '0;
  endtask

  task automatic t_reset();
    check("R1 lines", 64'(irq_line), 64'h00FF0000);
    check("R1 status", 64'(status), 0);
    check("R1 msg_valid", 64'(msg_valid), 0);
    check("R1 pit_gate_en", 64'(pit_gate_en), 1);
  endtask

  task automatic t_route_level();
    ch_level[2] = 1'b1;
    set_route(2, 5);
    fire(4'b0100);
    check("R2 line5 routed", 64'(irq_line[5]), 1);
    check("R3 status set", 64'(status), 64'h4);
    step();
    check("R3 level held", 64'(irq_line[5]), 1);
    clear_all();
    set_route(1, 31);
    ch_level[1] = 1'b1;
    fire(4'b0010);
    check("R2 out of range route", 64'(irq_line), 64'h00FF0000);
    clear_all();
    ch_level[1] = 1'b0;
  endtask

  task automatic t_w1c();
    fire(4'b0100);
    sts_clr_we = 1'b1;
    sts_clr_mask = 4'b1011;
    step();
    sts_clr_we = 1'b0;
    check("R3 zero mask bit keeps status", 64'(status[2]), 1);
    check("R3 zero mask bit keeps line", 64'(irq_line[5]), 1);
    sts_clr_we = 1'b1;
    sts_clr_mask = 4'b0100;
    step();
    sts_clr_we = 1'b0;
    check("R3 w1c status", 64'(status[2]), 0);
    check("R3 w1c line", 64'(irq_line[5]), 0);
    expire = 4'b0100;
    sts_clr_we = 1'b1;
    step();
    expire = '0;
    sts_clr_we = 1'b0;
    check("R3 expiry beats clear", 64'(status[2]), 1);
    clear_all();
  endtask

  task automatic t_edge();
    ch_level[3] = 1'b0;
    set_route(3, 6);
    fire(4'b1000);
    check("R4 edge pulse high", 64'(irq_line[6]), 1);
    check("R4 edge no status", 64'(status[3]), 0);
    step();
    check("R4 edge pulse one cycle", 64'(irq_line[6]), 0);
    set_route(3, 31);
  endtask

  task automatic t_invert();
    set_route(2, 17);
    check("R5 idle high", 64'(irq_line[17]), 1);
    fire(4'b0100);
    check("R5 asserted low", 64'(irq_line[17]), 0);
    clear_all();
    check("R5 released high", 64'(irq_line[17]), 1);
    set_route(2, 5);
  endtask

  task automatic t_legacy_route();
    legacy_mode = 1'b1;
    ch_level[1:0] = 2'b11;
    set_route(0, 3);
    set_route(1, 4);
    fire(4'b0011);
    check("R6 ch0 to line0", 64'(irq_line[0]), 1);
    check("R6 ch1 to line8", 64'(irq_line[8]), 1);
    check("R6 route field unused", 64'({irq_line[4], irq_line[3]}), 0);
    clear_all();
    legacy_mode = 1'b0;
    fire(4'b0001);
    check("R2 ch0 own route after legacy", 64'(irq_line[3]), 1);
    clear_all();
    set_route(0, 31);
    set_route(1, 31);
    ch_level[1:0] = 2'b00;
    step();
  endtask

  task automatic t_gating();
    fire(4'b0100);
    glob_en = 1'b0;
    step();
    check("R7 global off clears status", 64'(status), 0);
    check("R7 global off drops line", 64'(irq_line[5]), 0);
    fire(4'b0100);
    check("R7 expiry ignored while off", 64'(irq_line[5]), 0);
    glob_en = 1'b1;
    ch_en[2] = 1'b0;
    fire(4'b0100);
    check("R7 channel off ignores expiry", 64'(status), 0);
    ch_en[2] = 1'b1;
    step();
  endtask

  task automatic t_msg();
    int n;
    ch_msg_en[1] = 1'b1;
    ch_level[1] = 1'b1;
    set_route(1, 5);
    ch_msg_addr[32 +: 32] = 32'hFEE0_1000;
    ch_msg_data[32 +: 32] = 32'h0000_0041;
    msg_ready = 1'b0;
    fire(4'b0010);
    check("R8 no line in message mode", 64'(irq_line[5]), 0);
    check("R8 no status in message mode", 64'(status[1]), 0);
    check("R8 not yet valid", 64'(msg_valid), 0);
    step();
    check("R8 valid", 64'(msg_valid), 1);
    check("R8 address", 64'(msg_addr), 64'hFEE01000);
    check("R8 data", 64'(msg_data), 64'h41);
    fire(4'b0010);
    step();
    check("R8 held without ready", 64'({msg_valid, msg_data}), 64'h1_00000041);
    msg_ready = 1'b1;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      if (msg_valid) n++;
      step();
    end
    check("R8 one write per expiry", 64'(n), 2);
    check("R8 idle after drain", 64'(msg_valid), 0);
    msg_ready = 1'b0;
    ch_msg_en[1] = 1'b0;
    ch_level[1] = 1'b0;
    set_route(1, 31);
  endtask

  task automatic t_msg_en_clear();
    fire(4'b0100);
    check("R9 status set before", 64'(status[2]), 1);
    ch_msg_en[2] = 1'b1;
    step();
    check("R9 msg enable clears status", 64'(status[2]), 0);
    check("R9 msg enable drops line", 64'(irq_line[5]), 0);
    ch_msg_en[2] = 1'b0;
    step();
  endtask

  task automatic t_legacy_ext();
    pit_in = 1'b1;
    rtc_in = 1'b1;
    step();
    check("R11 pit passes", 64'(irq_line[0]), 1);
    check("R11 rtc passes", 64'(irq_line[8]), 1);
    legacy_mode = 1'b1;
    step();
    check("R10 pit blocked", 64'(irq_line[0]), 0);
    check("R10 rtc blocked", 64'(irq_line[8]), 0);
    check("R10 pit gate low", 64'(pit_gate_en), 0);
    rtc_in = 1'b0;
    step();
    rtc_in = 1'b1;
    step();
    check("R10 rtc still blocked", 64'(irq_line[8]), 0);
    legacy_mode = 1'b0;
    step();
    check("R11 line0 lowered on exit", 64'(irq_line[0]), 0);
    check("R11 line8 restored", 64'(irq_line[8]), 1);
    check("R11 pit gate high", 64'(pit_gate_en), 1);
    pit_in = 1'b0;
    step();
    pit_in = 1'b1;
    step();
    check("R11 pit change seen", 64'(irq_line[0]), 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_route_level();
    t_w1c();
    t_edge();
    t_invert();
    t_legacy_route();
    t_gating();
    t_msg();
    t_msg_en_clear();
    t_legacy_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule